// File: doc/BRIEF.md
# SHA-1 Single-Block Coprocessor

This block computes the SHA-1 compression of one 512-bit message block for a host. The host fills a 64-byte buffer through a plain synchronous byte port, where each byte can be written or read back at its own offset. It then raises a run input for one clock. The engine copies the buffer, starts from the standard SHA-1 initial values, and works through the 80 rounds at one round per clock. A busy flag stays high for the whole computation.

When busy drops, the 160-bit digest can be read as five 32-bit result words, A through E, which a three-bit selector picks. The hardware adds no padding and does no chaining. The host supplies a block that is already padded, and a run always starts from the fixed initial values. The buffer is locked against writes while busy is high, and a run request during a computation is dropped.

Top module: `sha1_block_cop`

## Requirements
- R1: After reset, busy is low, every result word reads 0, and every buffer byte reads 0.
- R2: While busy is low, a write with `buf_wr` high stores `buf_wdata` at byte offset `buf_addr` (0 to 63), and `buf_rdata` combinationally returns the byte stored at `buf_addr`.
- R3: Buffer bytes are packed big-endian into sixteen message words: byte 4k+j supplies bits [31-8j:24-8j] of word k, for k = 0 to 15 and j = 0 to 3.
- R4: A clock edge with `run` high and busy low starts a computation, and busy is high from the next cycle on.
- R5: Busy stays high for exactly 80 clock cycles per computation, one cycle for each round.
- R6: When busy falls, `res_sel` values 0, 1, 2, 3 and 4 read A, B, C, D and E of the digest. Each word is the standard initial value plus the working variable after 80 rounds. Selector values 5 to 7 read 0.
- R7: `run` is ignored while busy is high. The computation keeps its round count and its result.
- R8: Buffer writes are ignored while busy is high, and the byte at the written offset keeps its old value.
- R9: Result words keep their values until the next computation completes. The buffer is not changed by a computation, so running again without reloading gives the same digest.
- R10: No padding is applied. A block that holds the padded three-byte message "abc" gives a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_addr | input | 6 | Byte offset in the input buffer |
| buf_wr | input | 1 | Byte write strobe |
| buf_wdata | input | 8 | Byte to write |
| buf_rdata | output | 8 | Byte stored at `buf_addr` |
| run | input | 1 | Start request, one cycle |
| busy | output | 1 | High while the rounds are running |
| res_sel | input | 3 | Result word select: 0 = A to 4 = E |
| res_data | output | 32 | Selected result word |

## Verification
The checker assumes that `buf_addr` and `res_sel` are held steady whenever it compares the read-back byte or result word across a clock. Without that, a change in what is read back could come from a change of address rather than a write or an update. The bench changes addresses only during buffer loads, and it changes the selector only while busy is low. The digest comparison is therefore made on result words that no stray write or run pulse could have disturbed. The bench also deliberately pulses `run` and writes a byte in the middle of one computation, so the assertions see the blocked paths exercised as well as idle.

// File: rtl/sha1_cop_pkg.sv
package sha1_cop_pkg;

  localparam int WORD_W = 32;

  typedef struct packed {
    logic [WORD_W-1:0] a;
    logic [WORD_W-1:0] b;
    logic [WORD_W-1:0] c;
    logic [WORD_W-1:0] d;
    logic [WORD_W-1:0] e;
  } sha_state_t;

  localparam sha_state_t IV = '{
    a: 32'h67452301,
    b: 32'hEFCDAB89,
    c: 32'h98BADCFE,
    d: 32'h10325476,
    e: 32'hC3D2E1F0
  };

  function automatic logic [WORD_W-1:0] rotl(input logic [WORD_W-1:0] x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  // Logical function of the current stage of 20 rounds
  function automatic logic [WORD_W-1:0] mix_fn(input logic [1:0] stage,
                                               input logic [WORD_W-1:0] b,
                                               input logic [WORD_W-1:0] c,
                                               input logic [WORD_W-1:0] d);
    case (stage)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] stage_const(input logic [1:0] stage);
    case (stage)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

  function automatic sha_state_t round_step(input sha_state_t s,
                                            input logic [WORD_W-1:0] w,
                                            input logic [1:0] stage);
    sha_state_t n;
    n.a = rotl(s.a, 5) + mix_fn(stage, s.b, s.c, s.d) + s.e + stage_const(stage) + w;
    n.b = s.a;
    n.c = rotl(s.b, 30);
    n.d = s.c;
    n.e = s.d;
    return n;
  endfunction

  function automatic logic [WORD_W-1:0] sched_next(input logic [WORD_W-1:0] w_old,
                                                   input logic [WORD_W-1:0] w_m14,
                                                   input logic [WORD_W-1:0] w_m8,
                                                   input logic [WORD_W-1:0] w_m3);
    return rotl(w_old ^ w_m14 ^ w_m8 ^ w_m3, 1);
  endfunction

  function automatic logic [WORD_W-1:0] state_word(input sha_state_t s, input int idx);
    case (idx)
      0:       return s.a;
      1:       return s.b;
      2:       return s.c;
      3:       return s.d;
      default: return s.e;
    endcase
  endfunction

endpackage

// File: rtl/sha1_msg_buf.sv
module sha1_msg_buf #(
  parameter int BYTES  = 64,
  localparam int AW    = $clog2(BYTES),
  localparam int FLAT_W = BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [AW-1:0]     addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic [FLAT_W-1:0] flat
);

  logic [7:0] mem [BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BYTES; i++) mem[i] <= '0;
    end else if (wr_ok) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];

  // Byte 0 lands in the top bits, giving big-endian word packing
  for (genvar g = 0; g < BYTES; g++) begin : g_flat
    assign flat[FLAT_W-1-8*g -: 8] = mem[g];
  end

endmodule

// File: rtl/sha1_round_core.sv
module sha1_round_core
  import sha1_cop_pkg::*;
#(
  parameter int ROUNDS = 80,
  parameter int WINDOW = 16,
  localparam int RW      = $clog2(ROUNDS),
  localparam int STG     = ROUNDS / 4,
  localparam int BLOCK_W = WINDOW * WORD_W,
  localparam int TAP_M3  = WINDOW - 3,
  localparam int TAP_M8  = WINDOW - 8,
  localparam int TAP_M14 = WINDOW - 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [BLOCK_W-1:0] block,
  output logic               busy,
  output logic [RW-1:0]      round_idx,
  output logic               last_round,
  output sha_state_t         final_state
);

  logic [WORD_W-1:0] win [WINDOW];
  sha_state_t        st;
  sha_state_t        st_next;
  logic [1:0]        stage;

  always_comb begin
    if (round_idx < RW'(STG))          stage = 2'd0;
    else if (round_idx < RW'(2 * STG)) stage = 2'd1;
    else if (round_idx < RW'(3 * STG)) stage = 2'd2;
    else                               stage = 2'd3;
  end

  assign st_next     = round_step(st, win[0], stage);
  assign last_round  = busy && (round_idx == RW'(ROUNDS - 1));
  assign final_state = st_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      round_idx <= '0;
      st        <= '0;
    end else if (start) begin
      busy      <= 1'b1;
      round_idx <= '0;
      st        <= IV;
    end else if (busy) begin
      st        <= st_next;
      round_idx <= last_round ? '0 : round_idx + 1'b1;
      if (last_round) busy <= 1'b0;
    end
  end

  for (genvar g = 0; g < WINDOW; g++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        win[g] <= '0;
      end else if (start) begin
        win[g] <= block[BLOCK_W-1-WORD_W*g -: WORD_W];
      end else if (busy) begin
        if (g == WINDOW - 1)
          win[g] <= sched_next(win[0], win[TAP_M14], win[TAP_M8], win[TAP_M3]);
        else
          win[g] <= win[(g + 1) % WINDOW];
      end
    end
  end

endmodule

// File: rtl/sha1_result_regs.sv
module sha1_result_regs
  import sha1_cop_pkg::*;
#(
  parameter int NWORDS = 5,
  localparam int SW    = $clog2(NWORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  sha_state_t        fin,
  input  logic [SW-1:0]     sel,
  output logic [WORD_W-1:0] dout
);

  logic [WORD_W-1:0] hreg [NWORDS];

  for (genvar g = 0; g < NWORDS; g++) begin : g_h
    always_ff @(posedge clk) begin
      if (!rst_n)    hreg[g] <= '0;
      else if (load) hreg[g] <= state_word(IV, g) + state_word(fin, g);
    end
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NWORDS; i++)
      if (sel == SW'(i)) dout = hreg[i];
  end

endmodule

// File: rtl/sha1_block_cop.sv
module sha1_block_cop
  import sha1_cop_pkg::*;
#(
  parameter int BYTES  = 64,
  parameter int ROUNDS = 80,
  localparam int AW     = $clog2(BYTES),
  localparam int WINDOW = BYTES / 4,
  localparam int RW     = $clog2(ROUNDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] buf_addr,
  input  logic          buf_wr,
  input  logic [7:0]    buf_wdata,
  output logic [7:0]    buf_rdata,
  input  logic          run,
  output logic          busy,
  input  logic [2:0]    res_sel,
  output logic [31:0]   res_data
);

  logic [BYTES*8-1:0] flat;
  logic               start_evt;
  logic               wr_evt;
  logic               done_evt;
  logic [RW-1:0]      round_idx;
  sha_state_t         fin_state;

  assign start_evt = run && !busy;
  assign wr_evt    = buf_wr && !busy;

  sha1_msg_buf #(.BYTES(BYTES)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_ok (wr_evt),
    .addr  (buf_addr),
    .wdata (buf_wdata),
    .rdata (buf_rdata),
    .flat  (flat)
  );

  sha1_round_core #(.ROUNDS(ROUNDS), .WINDOW(WINDOW)) u_core (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start_evt),
    .block       (flat),
    .busy        (busy),
    .round_idx   (round_idx),
    .last_round  (done_evt),
    .final_state (fin_state)
  );

  sha1_result_regs #(.NWORDS(5)) u_res (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (done_evt),
    .fin   (fin_state),
    .sel   (res_sel),
    .dout  (res_data)
  );

endmodule

// File: rtl/sha1_cop_chk.sv
module sha1_cop_chk #(
  parameter int ROUNDS = 80,
  localparam int RW = $clog2(ROUNDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [5:0]    buf_addr,
  input logic          buf_wr,
  input logic [7:0]    buf_rdata,
  input logic          run,
  input logic          busy,
  input logic [2:0]    res_sel,
  input logic [31:0]   res_data,
  input logic          start_evt,
  input logic          done_evt,
  input logic [RW-1:0] round_idx
);

  logic        seen;
  logic [7:0]  busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen     <= 1'b0;
      busy_cnt <= '0;
    end else begin
      seen <= 1'b1;
      if (start_evt)  busy_cnt <= '0;
      else if (busy)  busy_cnt <= busy_cnt + 1'b1;
    end
  end

  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> busy);

  p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $fell(busy)) |-> (busy_cnt == 8'(ROUNDS)));

  p_round_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (round_idx < RW'(ROUNDS)));

  p_sel_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (res_sel > 3'd4) |-> (res_data == 32'd0));

  p_run_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && run && !done_evt) |=> (busy && round_idx == $past(round_idx) + 1'b1));

  p_write_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && $past(busy && buf_wr) && $stable(buf_addr)) |-> $stable(buf_rdata));

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !busy && $past(!busy) && $stable(res_sel)) |-> $stable(res_data));

endmodule

bind sha1_block_cop sha1_cop_chk #(.ROUNDS(ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .buf_addr  (buf_addr),
  .buf_wr    (buf_wr),
  .buf_rdata (buf_rdata),
  .run       (run),
  .busy      (busy),
  .res_sel   (res_sel),
  .res_data  (res_data),
  .start_evt (start_evt),
  .done_evt  (done_evt),
  .round_idx (round_idx)
);

// File: tb/sha1_block_cop_bench.sv
`timescale 1ns/1ps
module sha1_block_cop_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  buf_addr = '0;
  logic        buf_wr = 1'b0;
  logic [7:0]  buf_wdata = '0;
  logic [7:0]  buf_rdata;
  logic        run = 1'b0;
  logic        busy;
  logic [2:0]  res_sel = '0;
  logic [31:0] res_data;

  int total = 0;
  int bad = 0;

  logic [7:0]  model [64];
  logic [31:0] exp_q [$];
  bit          read_req = 1'b0;

  always #2 clk = ~clk;

  sha1_block_cop u_sha1_block_cop (.*);

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference digest, written as a full 80-word expansion
  function automatic logic [159:0] ref_digest(input logic [7:0] blk [64]);
    logic [31:0] w [80];
    logic [31:0] h0, h1, h2, h3, h4, a, b, c, d, e, f, k, t;
    h0 = 32'h67452301; h1 = 32'hEFCDAB89; h2 = 32'h98BADCFE;
    h3 = 32'h10325476; h4 = 32'hC3D2E1F0;
    for (int i = 0; i < 16; i++)
      w[i] = {blk[4*i], blk[4*i+1], blk[4*i+2], blk[4*i+3]};
    for (int i = 16; i < 80; i++) begin
      t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {t[30:0], t[31]};
    end
    a = h0; b = h1; c = h2; d = h3; e = h4;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = d ^ (b & (c ^ d));           k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (d & (b | c));     k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = {a[26:0], a[31:27]} + f + e + k + w[i];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
    end
    return {h0 + a, h1 + b, h2 + c, h3 + d, h4 + e};
  endfunction

  task automatic push_expected();
    logic [159:0] dg;
    dg = ref_digest(model);
    for (int i = 0; i < 5; i++) exp_q.push_back(dg[159-32*i -: 32]);
  endtask

  // Monitor: reads A..E when busy falls or on request, pops and compares
  initial begin : monitor
    bit prev_busy;
    logic [31:0] e;
    prev_busy = 1'b0;
    forever begin
      @(negedge clk);
      if ((prev_busy && !busy) || read_req) begin
        for (int i = 0; i < 5; i++) begin
          res_sel = 3'(i);
          #0.1;
          if (exp_q.size() == 0) begin
            check(1'b0, "R6 unexpected result", res_data, 32'h0);
          end else begin
            e = exp_q.pop_front();
            check(res_data === e, "R6/R3 digest word", res_data, e);
          end
        end
        res_sel = 3'd0;
        read_req = 1'b0;
      end
      prev_busy = busy;
    end
  end

  task automatic wr_byte(input int a, input logic [7:0] d);
    @(negedge clk);
    buf_addr = 6'(a); buf_wdata = d; buf_wr = 1'b1;
    model[a] = d;
    @(negedge clk);
    buf_wr = 1'b0;
  endtask

  task automatic load_and_verify(input string tag);
    int mism;
    for (int i = 0; i < 64; i++) wr_byte(i, model[i]);
    mism = 0;
    for (int i = 0; i < 64; i++) begin
      buf_addr = 6'(i);
      #0.1;
      if (buf_rdata !== model[i]) mism++;
    end
    check(mism == 0, {"R2 readback ", tag}, 32'(mism), 32'h0);
  endtask

  task automatic run_block(input bit disturb);
    int n;
    logic [7:0] keep;
    keep = model[5];
    push_expected();
    @(negedge clk);
    run = 1'b1;
    @(negedge clk);
    run = 1'b0;
    check(busy === 1'b1, "R4 busy after run", 32'(busy), 32'h1);
    n = 0;
    while (busy === 1'b1 && n < 200) begin
      n++;
      if (disturb && n == 10) begin
        run = 1'b1; buf_addr = 6'd5; buf_wdata = ~keep; buf_wr = 1'b1;
      end else begin
        run = 1'b0; buf_wr = 1'b0;
      end
      @(negedge clk);
    end
    run = 1'b0; buf_wr = 1'b0;
    check(n == 80, "R5 busy length", 32'(n), 32'd80);
    if (disturb) begin
      buf_addr = 6'd5;
      #0.1;
      check(buf_rdata === keep, "R8 write during busy", 32'(buf_rdata), 32'(keep));
      repeat (3) @(negedge clk);
      check(busy === 1'b0, "R7 run during busy not restarted", 32'(busy), 32'h0);
    end
    wait (exp_q.size() == 0);
    @(negedge clk);
  endtask

  initial begin : watchdog
    #(200000 * 4);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : driver
    logic [159:0] dg;
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(busy === 1'b0, "R1 busy at reset", 32'(busy), 32'h0);
    for (int i = 0; i < 5; i++) begin
      res_sel = 3'(i);
      #0.1;
      check(res_data === 32'h0, "R1 result at reset", res_data, 32'h0);
    end
    res_sel = 3'd0;
    buf_addr = 6'd63;
    #0.1;
    check(buf_rdata === 8'h00, "R1 buffer at reset", 32'(buf_rdata), 32'h0);

    // R10: padded "abc", R3 packing through a known digest
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    model[0] = 8'h61; model[1] = 8'h62; model[2] = 8'h63; model[3] = 8'h80;
    model[63] = 8'h18;
    load_and_verify("abc");
    dg = ref_digest(model);
    check(dg === 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R10 reference digest",
          dg[159:128], 32'ha9993e36);
    run_block(1'b0);
    res_sel = 3'd0;
    #0.1;
    check(res_data === 32'ha9993e36, "R10 word A", res_data, 32'ha9993e36);
    res_sel = 3'd4;
    #0.1;
    check(res_data === 32'h9cd0d89d, "R10 word E", res_data, 32'h9cd0d89d);
    for (int s = 5; s < 8; s++) begin
      res_sel = 3'(s);
      #0.1;
      check(res_data === 32'h0, "R6 select out of range", res_data, 32'h0);
    end
    res_sel = 3'd0;

    // R9 hold while idle, then rerun without reloading
    repeat (20) @(negedge clk);
    push_expected();
    read_req = 1'b1;
    wait (exp_q.size() == 0);
    @(negedge clk);
    run_block(1'b0);

    // all-zero block
    for (int i = 0; i < 64; i++) model[i] = 8'h00;
    load_and_verify("zeros");
    run_block(1'b0);

    // distinct byte pattern exercises R3 byte lanes
    for (int i = 0; i < 64; i++) model[i] = 8'((i * 37 + 11) ^ (i << 3));
    load_and_verify("pattern");
    run_block(1'b0);

    // all ones with run and write during busy: R7, R8
    for (int i = 0; i < 64; i++) model[i] = 8'hFF;
    load_and_verify("ones");
    run_block(1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule